// File: doc/BRIEF.md
# Two-Channel Serial Controller Register Access Unit

This block sits between a byte-wide host bus and the register files of a two-channel serial controller. Each bus access carries a two-bit address. One address bit picks the channel and the other picks whether the access goes to the channel's control port or to its data port. A strap input exchanges the roles of the two bits, so the same block fits boards that group the registers by channel and boards that group them by type.

Each channel has sixteen write registers and sixteen read registers, and only one control port reaches them. A per-channel pointer selects the register. The first control write sets the pointer. The second control write, or a control read, then reaches the pointed register, and the pointer falls back to zero after that access. A control write to register 0 also carries a three-bit command. The commands can extend the pointer into the upper bank, clear the transmit interrupt, or release the highest interrupt under service. Writing register 9 resets one channel or both, which reloads the registers with their non-zero defaults.

Each channel's pointer is a two-state machine. In `PTR_BASE` the pointer is zero. In `PTR_AIMED` the pointer holds a non-zero register number. Three transitions exist:
- `LOAD`: `PTR_BASE` to `PTR_AIMED`, on a control write that loads a non-zero pointer.
- `RETURN`: `PTR_AIMED` to `PTR_BASE`, on any control write or control read.
- `SOFT_RESET`: any state to `PTR_BASE`, on a channel reset request.

A control write or read in `PTR_BASE` that leaves the pointer at zero keeps the machine in `PTR_BASE`.

The outputs are registered one-cycle pulses, which go to the interrupt logic and to the line-parameter decoder, and a flat copy of both write register banks.

Top module: `sio_regacc`

## Requirements
- R1: Address decoding follows `layout_swap`. With `layout_swap`=0, `bus_addr[0]` selects data (1) or control (0) and `bus_addr[1]` selects the channel. With `layout_swap`=1 the two bits exchange roles. A data access raises `data_wr_stb[ch]` or `data_rd_stb[ch]` combinationally during the access cycle.
- R2: A control write while the channel's pointer is 0 loads pointer bits 2:0 from data bits 2:0. When data bits 5:3 equal 3'b001, the write also sets pointer bit 3, which reaches registers 8 to 15.
- R3: A control write to a non-zero register returns the pointer to 0. A control read returns the pointed read register and clears the pointer to 0. Data accesses leave both pointers unchanged.
- R4: A control write to register 0 raises a one-cycle pulse in the following cycle, on the accessed channel's bit: `clr_txint_pls` for command 3'b101 and `rst_ius_pls` for command 3'b111. Other commands, and writes to non-zero registers, raise neither pulse.
- R5: A write to register 9 decodes data bits 7:6 and raises `chan_rst_pls` for one cycle in the following cycle. 2'b01 resets channel 0, 2'b10 resets channel 1, 2'b11 resets both, and 2'b00 resets nothing. Register 9 never stores the written value. A reset channel's pointer returns to 0.
- R6: After the hardware reset or a channel reset, the write registers of that channel hold: register 4 = 0x04, register 9 = 0xC0, register 11 = 0x08, register 14 = 0x30, register 15 = 0xF8, and 0x00 in all others.
- R7: Read register 1 returns 0x07. Read register 0 returns 0x44, or 0x7C when the channel's `line_absent` bit is set. Read registers other than 0, 1, 12 and 13 return 0x00.
- R8: Writes to registers 12 and 13 are mirrored into read registers 12 and 13. A channel reset clears the mirrors to 0x00.
- R9: A write to register 4, 5, 12 or 13 raises `param_upd_pls[ch]` for one cycle in the following cycle. No other access raises it.
- R10: Only `bus_wdata[7:0]` is used. The upper bus bits have no effect on the registers or the pointer.
- R11: Writes to registers 1 to 8 and 10 to 15 are stored in the accessed channel's bank only. Write register n of channel c appears at `wreg_bank[(c*16+n)*8 +: 8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| layout_swap | input | 1 | Exchanges the roles of the two address bits |
| line_absent | input | 2 | Per channel: line not connected; changes read register 0 |
| bus_en | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Channel and control/data select |
| bus_wdata | input | BUS_W | Write data; only bits 7:0 are used |
| bus_rdata | output | 8 | Read data of a control read, 0 otherwise |
| data_wr_stb | output | 2 | Data port write strobe per channel |
| data_rd_stb | output | 2 | Data port read strobe per channel |
| clr_txint_pls | output | 2 | Clear-transmit-interrupt pulse per channel |
| rst_ius_pls | output | 2 | Release-highest-under-service pulse per channel |
| param_upd_pls | output | 2 | Line-parameter update pulse per channel |
| chan_rst_pls | output | 2 | Channel reset pulse |
| wreg_bank | output | 256 | Both write register banks, flattened |

## Verification
The bench targets the pointer's two-step sequence and its return to zero after writes and after reads. A design that skipped the return would send the next control write into a data register rather than the pointer. The bench also tests the point-high command against a plain pointer load of the same low bits, so that an ignored bit 3 would hit register 4 where register 12 was meant.

For the reset codes, the bench issues a reset of the other channel and checks that the accessed channel keeps its values. It also checks that register 9 keeps 0xC0, and that a channel reset while the pointer is aimed sends the pointer home. Swapped layouts and wide data with junk in the upper bits catch address bits taken in the wrong role and data bits taken above bit 7.

// File: rtl/sio_regacc_pkg.sv
package sio_regacc_pkg;

    localparam int NUM_CH = 2;
    localparam int NREG   = 16;
    localparam int REG_W  = 8;
    localparam int PTR_W  = $clog2(NREG);

    typedef enum logic [0:0] {
        PTR_BASE  = 1'b0,
        PTR_AIMED = 1'b1
    } ptr_state_e;

    typedef enum logic [2:0] {
        CMD_NULL     = 3'b000,
        CMD_POINT_HI = 3'b001,
        CMD_CLR_TX   = 3'b101,
        CMD_RST_IUS  = 3'b111
    } cmd_e;

    localparam logic [PTR_W-1:0] REG_CMD     = 4'd0;
    localparam logic [PTR_W-1:0] REG_ONES    = 4'd1;
    localparam logic [PTR_W-1:0] REG_MODE    = 4'd4;
    localparam logic [PTR_W-1:0] REG_FMT     = 4'd5;
    localparam logic [PTR_W-1:0] REG_MASTER  = 4'd9;
    localparam logic [PTR_W-1:0] REG_BAUD_LO = 4'd12;
    localparam logic [PTR_W-1:0] REG_BAUD_HI = 4'd13;

    localparam logic [REG_W-1:0] RD1_CONST = 8'h07;

    function automatic logic [REG_W-1:0] wreg_reset_val(input logic [PTR_W-1:0] idx);
        case (idx)
            4'd4:    return 8'h04;
            4'd9:    return 8'hC0;
            4'd11:   return 8'h08;
            4'd14:   return 8'h30;
            4'd15:   return 8'hF8;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/regacc_addr_dec.sv
module regacc_addr_dec
    import sio_regacc_pkg::*;
(
    input  logic              layout_swap,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    output logic [NUM_CH-1:0] ctrl_wr,
    output logic [NUM_CH-1:0] ctrl_rd,
    output logic [NUM_CH-1:0] dat_wr,
    output logic [NUM_CH-1:0] dat_rd
);

    logic is_data;
    logic ch_sel;

    always_comb begin
        if (layout_swap) begin
            is_data = bus_addr[1];
            ch_sel  = bus_addr[0];
        end else begin
            is_data = bus_addr[0];
            ch_sel  = bus_addr[1];
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : gen_dec
        logic hit;
        assign hit        = bus_en && (ch_sel == 1'(c));
        assign ctrl_wr[c] = hit &&  bus_we && !is_data;
        assign ctrl_rd[c] = hit && !bus_we && !is_data;
        assign dat_wr[c]  = hit &&  bus_we &&  is_data;
        assign dat_rd[c]  = hit && !bus_we &&  is_data;
    end

endmodule

// File: rtl/regacc_rst_ctl.sv
module regacc_rst_ctl
    import sio_regacc_pkg::*;
(
    input  logic [NUM_CH-1:0] master_wr,
    input  logic [REG_W-1:0]  wdata,
    output logic [NUM_CH-1:0] soft_rst
);

    logic [1:0] code;
    assign code = wdata[7:6];

    // Bit c of the code requests a reset of channel c; both set resets both.
    for (genvar c = 0; c < NUM_CH; c++) begin : gen_rst
        assign soft_rst[c] = (|master_wr) && code[c];
    end

endmodule

// File: rtl/regacc_chan.sv
module regacc_chan
    import sio_regacc_pkg::*;
#(
    parameter logic [REG_W-1:0] STAT_IDLE   = 8'h44,
    parameter logic [REG_W-1:0] STAT_ABSENT = 8'h7C
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   line_absent,
    input  logic                   soft_rst,
    input  logic                   ctrl_wr,
    input  logic                   ctrl_rd,
    input  logic [REG_W-1:0]       wdata,
    output logic [REG_W-1:0]       rdata,
    output logic                   master_wr,
    output logic [PTR_W-1:0]       ptr,
    output logic [NREG*REG_W-1:0]  wregs_flat,
    output logic                   clr_tx_pls,
    output logic                   rst_ius_pls,
    output logic                   param_pls,
    output logic                   rst_pls
);

    ptr_state_e            state_q, state_d;
    logic [PTR_W-1:0]      ptr_q, ptr_d;
    logic [REG_W-1:0]      wregs_q [NREG];
    logic [REG_W-1:0]      baud_lo_q, baud_hi_q;
    cmd_e                  cmd;
    logic                  reg_wr;
    logic                  is_param_reg;

    assign cmd = cmd_e'(wdata[5:3]);

    // Next-state logic of the pointer machine.
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            PTR_BASE: begin
                if (ctrl_wr) begin
                    ptr_d   = {(cmd == CMD_POINT_HI), wdata[2:0]};
                    state_d = (ptr_d != REG_CMD) ? PTR_AIMED : PTR_BASE;
                end
            end
            PTR_AIMED: begin
                if (ctrl_wr || ctrl_rd) begin
                    ptr_d   = REG_CMD;
                    state_d = PTR_BASE;
                end
            end
        endcase
        if (soft_rst) begin
            ptr_d   = REG_CMD;
            state_d = PTR_BASE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PTR_BASE;
            ptr_q   <= REG_CMD;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    assign ptr       = ptr_q;
    assign master_wr = ctrl_wr && (state_q == PTR_AIMED) && (ptr_q == REG_MASTER);
    assign reg_wr    = ctrl_wr && (state_q == PTR_AIMED) && (ptr_q != REG_MASTER);
    assign is_param_reg = (ptr_q == REG_MODE) || (ptr_q == REG_FMT) ||
                          (ptr_q == REG_BAUD_LO) || (ptr_q == REG_BAUD_HI);

    // Write register bank; register 9 only ever holds its default.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) wregs_q[i] <= wreg_reset_val(PTR_W'(i));
        end else if (soft_rst) begin
            for (int i = 0; i < NREG; i++) wregs_q[i] <= wreg_reset_val(PTR_W'(i));
        end else if (reg_wr) begin
            wregs_q[ptr_q] <= wdata;
        end
    end

    // Read-side mirrors of the baud divisor.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            baud_lo_q <= '0;
            baud_hi_q <= '0;
        end else if (soft_rst) begin
            baud_lo_q <= '0;
            baud_hi_q <= '0;
        end else if (reg_wr && (ptr_q == REG_BAUD_LO)) begin
            baud_lo_q <= wdata;
        end else if (reg_wr && (ptr_q == REG_BAUD_HI)) begin
            baud_hi_q <= wdata;
        end
    end

    for (genvar i = 0; i < NREG; i++) begin : gen_flat
        assign wregs_flat[i*REG_W +: REG_W] = wregs_q[i];
    end

    always_comb begin
        case (ptr_q)
            REG_CMD:     rdata = line_absent ? STAT_ABSENT : STAT_IDLE;
            REG_ONES:    rdata = RD1_CONST;
            REG_BAUD_LO: rdata = baud_lo_q;
            REG_BAUD_HI: rdata = baud_hi_q;
            default:     rdata = '0;
        endcase
    end

    // Registered output pulses.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_tx_pls  <= 1'b0;
            rst_ius_pls <= 1'b0;
            param_pls   <= 1'b0;
            rst_pls     <= 1'b0;
        end else begin
            clr_tx_pls  <= ctrl_wr && (state_q == PTR_BASE) && (cmd == CMD_CLR_TX);
            rst_ius_pls <= ctrl_wr && (state_q == PTR_BASE) && (cmd == CMD_RST_IUS);
            param_pls   <= reg_wr && is_param_reg;
            rst_pls     <= soft_rst;
        end
    end

endmodule

// File: rtl/sio_regacc.sv
module sio_regacc
    import sio_regacc_pkg::*;
#(
    parameter int               BUS_W       = 32,
    parameter logic [7:0]       STAT_IDLE   = 8'h44,
    parameter logic [7:0]       STAT_ABSENT = 8'h7C
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          layout_swap,
    input  logic [1:0]                    line_absent,
    input  logic                          bus_en,
    input  logic                          bus_we,
    input  logic [1:0]                    bus_addr,
    input  logic [BUS_W-1:0]              bus_wdata,
    output logic [7:0]                    bus_rdata,
    output logic [1:0]                    data_wr_stb,
    output logic [1:0]                    data_rd_stb,
    output logic [1:0]                    clr_txint_pls,
    output logic [1:0]                    rst_ius_pls,
    output logic [1:0]                    param_upd_pls,
    output logic [1:0]                    chan_rst_pls,
    output logic [2*16*8-1:0]             wreg_bank
);

    localparam int BANK_W = NREG * REG_W;

    logic [NUM_CH-1:0]       ctrl_wr, ctrl_rd;
    logic [NUM_CH-1:0]       master_wr, soft_rst;
    logic [REG_W-1:0]        wdata8;
    logic [REG_W-1:0]        ch_rdata [NUM_CH];
    logic [NUM_CH*PTR_W-1:0] ptr_all;
    logic                    unused_hi_bits;

    assign wdata8         = bus_wdata[REG_W-1:0];
    assign unused_hi_bits = ^bus_wdata[BUS_W-1:REG_W];

    regacc_addr_dec u_dec (
        .layout_swap (layout_swap),
        .bus_en      (bus_en),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .ctrl_wr     (ctrl_wr),
        .ctrl_rd     (ctrl_rd),
        .dat_wr      (data_wr_stb),
        .dat_rd      (data_rd_stb)
    );

    regacc_rst_ctl u_rst (
        .master_wr (master_wr),
        .wdata     (wdata8),
        .soft_rst  (soft_rst)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : gen_ch
        regacc_chan #(
            .STAT_IDLE   (STAT_IDLE),
            .STAT_ABSENT (STAT_ABSENT)
        ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .line_absent (line_absent[c]),
            .soft_rst    (soft_rst[c]),
            .ctrl_wr     (ctrl_wr[c]),
            .ctrl_rd     (ctrl_rd[c]),
            .wdata       (wdata8),
            .rdata       (ch_rdata[c]),
            .master_wr   (master_wr[c]),
            .ptr         (ptr_all[c*PTR_W +: PTR_W]),
            .wregs_flat  (wreg_bank[c*BANK_W +: BANK_W]),
            .clr_tx_pls  (clr_txint_pls[c]),
            .rst_ius_pls (rst_ius_pls[c]),
            .param_pls   (param_upd_pls[c]),
            .rst_pls     (chan_rst_pls[c])
        );
    end

    always_comb begin
        if (ctrl_rd[1])      bus_rdata = ch_rdata[1];
        else if (ctrl_rd[0]) bus_rdata = ch_rdata[0];
        else                 bus_rdata = '0;
    end

endmodule

// File: rtl/sio_regacc_chk.sv
module sio_regacc_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         layout_swap,
    input logic         bus_en,
    input logic         bus_we,
    input logic [1:0]   bus_addr,
    input logic [7:0]   wd8,
    input logic [7:0]   ptr_all,
    input logic [255:0] wreg_bank,
    input logic [1:0]   data_wr_stb,
    input logic [1:0]   data_rd_stb,
    input logic [1:0]   clr_txint_pls,
    input logic [1:0]   rst_ius_pls,
    input logic [1:0]   param_upd_pls,
    input logic [1:0]   chan_rst_pls
);

    logic k_data, k_ch;
    assign k_data = layout_swap ? bus_addr[1] : bus_addr[0];
    assign k_ch   = layout_swap ? bus_addr[0] : bus_addr[1];

    // R1: at most one data strobe per cycle
    p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_wr_stb, data_rd_stb}));

    // R3: data accesses leave the pointers alone
    p_data_keeps_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && k_data) |=> $stable(ptr_all));

    // R4: the two command pulses never coincide
    p_cmd_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_txint_pls & rst_ius_pls) == 2'b00);

    // R9: a parameter pulse always follows a bus write
    p_param_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (param_upd_pls != 2'b00) |-> $past(bus_en && bus_we));

    for (genvar c = 0; c < 2; c++) begin : gen_p
        logic cw, cr;
        assign cw = bus_en && bus_we && !k_data && (k_ch == 1'(c));
        assign cr = bus_en && !bus_we && !k_data && (k_ch == 1'(c));

        // R3: write to a non-zero register sends the pointer home
        p_ptr_home_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (cw && ptr_all[c*4 +: 4] != 4'd0) |=> (ptr_all[c*4 +: 4] == 4'd0));

        // R3: control read sends the pointer home
        p_rd_home_r3: assert property (@(posedge clk) disable iff (!rst_n)
            cr |=> (ptr_all[c*4 +: 4] == 4'd0));

        // R2: point-high command sets pointer bit 3
        p_point_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (cw && ptr_all[c*4 +: 4] == 4'd0 && wd8[5:3] == 3'b001 && chan_rst_pls == 2'b00)
            |=> ptr_all[c*4 + 3]);

        // R4: clear-transmit command yields its pulse
        p_clr_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cw && ptr_all[c*4 +: 4] == 4'd0 && wd8[5:3] == 3'b101) |=> clr_txint_pls[c]);

        // R6: a channel reset leaves the defaults in place
        p_rst_dflt_r6: assert property (@(posedge clk) disable iff (!rst_n)
            chan_rst_pls[c] |-> (wreg_bank[(c*16+4)*8 +: 8] == 8'h04 &&
                                 wreg_bank[(c*16+15)*8 +: 8] == 8'hF8 &&
                                 ptr_all[c*4 +: 4] == 4'd0));
    end

endmodule

bind sio_regacc sio_regacc_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .layout_swap   (layout_swap),
    .bus_en        (bus_en),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .wd8           (bus_wdata[7:0]),
    .ptr_all       (ptr_all),
    .wreg_bank     (wreg_bank),
    .data_wr_stb   (data_wr_stb),
    .data_rd_stb   (data_rd_stb),
    .clr_txint_pls (clr_txint_pls),
    .rst_ius_pls   (rst_ius_pls),
    .param_upd_pls (param_upd_pls),
    .chan_rst_pls  (chan_rst_pls)
);

// File: tb/sim_sio_regacc.sv
`timescale 1ns/1ps
module sim_sio_regacc;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         layout_swap = 1'b0;
    logic [1:0]   line_absent = 2'b10;
    logic         bus_en = 1'b0;
    logic         bus_we = 1'b0;
    logic [1:0]   bus_addr = 2'b00;
    logic [31:0]  bus_wdata = '0;
    logic [7:0]   bus_rdata;
    logic [1:0]   data_wr_stb, data_rd_stb;
    logic [1:0]   clr_txint_pls, rst_ius_pls, param_upd_pls, chan_rst_pls;
    logic [255:0] wreg_bank;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    logic [7:0] last_rd;
    logic [1:0] last_dws, last_drs;
    logic [1:0] p_clr, p_ius, p_par, p_rst;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_regacc u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .layout_swap   (layout_swap),
        .line_absent   (line_absent),
        .bus_en        (bus_en),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .data_wr_stb   (data_wr_stb),
        .data_rd_stb   (data_rd_stb),
        .clr_txint_pls (clr_txint_pls),
        .rst_ius_pls   (rst_ius_pls),
        .param_upd_pls (param_upd_pls),
        .chan_rst_pls  (chan_rst_pls),
        .wreg_bank     (wreg_bank)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] wreg(input int ch, input int idx);
        return wreg_bank[(ch*16+idx)*8 +: 8];
    endfunction

    function automatic logic [7:0] exp_def(input int idx);
        case (idx)
            4:  return 8'h04;
            9:  return 8'hC0;
            11: return 8'h08;
            14: return 8'h30;
            15: return 8'hF8;
            default: return 8'h00;
        endcase
    endfunction

    task automatic access(input bit ch, input bit is_data, input bit we, input logic [31:0] wd);
        @(negedge clk);
        bus_en    = 1'b1;
        bus_we    = we;
        bus_addr  = layout_swap ? {is_data, ch} : {ch, is_data};
        bus_wdata = wd;
        #1;
        last_rd  = bus_rdata;
        last_dws = data_wr_stb;
        last_drs = data_rd_stb;
        @(negedge clk);
        bus_en = 1'b0;
        bus_we = 1'b0;
        p_clr = clr_txint_pls;
        p_ius = rst_ius_pls;
        p_par = param_upd_pls;
        p_rst = chan_rst_pls;
    endtask

    task automatic cw(input bit ch, input logic [31:0] v);
        access(ch, 1'b0, 1'b1, v);
    endtask

    task automatic cr(input bit ch);
        access(ch, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_reset;
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < 16; i++)
                chk($sformatf("R6 reset wreg ch%0d r%0d", c, i), wreg(c, i), exp_def(i));
        cr(0); chk("R7 rreg0 ch0 present", last_rd, 8'h44);
        cr(1); chk("R7 rreg0 ch1 absent", last_rd, 8'h7C);
        cw(0, 8'h01); cr(0); chk("R7 rreg1", last_rd, 8'h07);
        cw(0, 8'h02); cr(0); chk("R7 unimplemented rreg2", last_rd, 8'h00);
    endtask

    task automatic t_pointer;
        cw(0, 8'h04); chk("R9 pointer load no param", p_par, 2'b00);
        cw(0, 8'h3F); chk("R11 reg4 stored", wreg(0, 4), 8'h3F);
        chk("R9 param on reg4", p_par, 2'b01);
        cw(0, 8'h03); cw(0, 8'hA5);
        chk("R3 pointer returned, reg3 stored", wreg(0, 3), 8'hA5);
        chk("R9 no param on reg3", p_par, 2'b00);
        chk("R11 other channel untouched", wreg(1, 3), 8'h00);
        cw(0, 8'h01); cr(0); chk("R3 read pointed reg", last_rd, 8'h07);
        cr(0); chk("R3 read cleared pointer", last_rd, 8'h44);
    endtask

    task automatic t_point_high;
        cw(1, 8'h0C); cw(1, 8'h34);
        chk("R2 point-high reaches reg12", wreg(1, 12), 8'h34);
        chk("R9 param on reg12", p_par, 2'b10);
        cw(1, 8'h0D); cw(1, 8'h12);
        chk("R2 point-high reaches reg13", wreg(1, 13), 8'h12);
        cw(1, 8'h0C); cr(1); chk("R8 mirror reg12", last_rd, 8'h34);
        cw(1, 8'h0D); cr(1); chk("R8 mirror reg13", last_rd, 8'h12);
        cw(1, 8'h0F); cw(1, 8'h11); chk("R2 reg15 via point-high", wreg(1, 15), 8'h11);
        cw(1, 8'h04); cw(1, 8'h55);
        chk("R2 plain load hits reg4", wreg(1, 4), 8'h55);
        chk("R2 reg12 kept", wreg(1, 12), 8'h34);
    endtask

    task automatic t_commands;
        cw(0, 8'h28); chk("R4 clr tx pulse", p_clr, 2'b01); chk("R4 no ius", p_ius, 2'b00);
        cw(0, 8'h38); chk("R4 ius pulse", p_ius, 2'b01); chk("R4 no clr", p_clr, 2'b00);
        cw(1, 8'h28); chk("R4 clr tx ch1", p_clr, 2'b10);
        cw(0, 8'h10); chk("R4 other cmd no clr", p_clr, 2'b00); chk("R4 other cmd no ius", p_ius, 2'b00);
        cr(0); chk("R3 pointer zero after commands", last_rd, 8'h44);
        cw(0, 8'h29); chk("R4 clr with pointer", p_clr, 2'b01);
        cr(0); chk("R2 pointer loaded with command", last_rd, 8'h07);
        cw(0, 8'h05); cw(0, 8'h28);
        chk("R4 cmd bits in reg5 no pulse", p_clr, 2'b00);
        chk("R9 param on reg5", p_par, 2'b01);
        chk("R11 reg5 stored", wreg(0, 5), 8'h28);
    endtask

    task automatic t_data;
        cw(0, 8'h01);
        access(1'b0, 1'b1, 1'b1, 32'h5A);
        chk("R1 data write strobe ch0", last_dws, 2'b01); chk("R1 no read strobe", last_drs, 2'b00);
        access(1'b1, 1'b1, 1'b0, 32'h0);
        chk("R1 data read strobe ch1", last_drs, 2'b10);
        cr(0); chk("R3 data access kept pointer", last_rd, 8'h07);
    endtask

    task automatic t_resets;
        cw(1, 8'h09); cw(1, 8'h40);
        chk("R5 code 01 pulse", p_rst, 2'b01);
        chk("R6 ch0 reg4 default", wreg(0, 4), 8'h04);
        chk("R6 ch0 reg3 cleared", wreg(0, 3), 8'h00);
        chk("R5 ch1 kept", wreg(1, 4), 8'h55);
        chk("R5 reg9 not stored", wreg(1, 9), 8'hC0);
        cw(1, 8'h01); cr(1); chk("R5 writer pointer home", last_rd, 8'h07);
        cw(1, 8'h03);
        cw(0, 8'h09); cw(0, 8'h80);
        chk("R5 code 10 pulse", p_rst, 2'b10);
        chk("R6 ch1 reg4 default", wreg(1, 4), 8'h04);
        chk("R6 ch1 reg12 cleared", wreg(1, 12), 8'h00);
        cw(1, 8'h01); cr(1); chk("R5 reset channel pointer home", last_rd, 8'h07);
        chk("R5 aimed write did not land", wreg(1, 3), 8'h00);
        cw(1, 8'h0C); cr(1); chk("R8 mirror cleared", last_rd, 8'h00);
        cw(0, 8'h0A); cw(0, 8'h77); cw(1, 8'h0A); cw(1, 8'h66);
        cw(0, 8'h09); cw(0, 8'hC0);
        chk("R5 code 11 pulse", p_rst, 2'b11);
        chk("R6 ch0 reg10 cleared", wreg(0, 10), 8'h00);
        chk("R6 ch1 reg10 cleared", wreg(1, 10), 8'h00);
        cw(0, 8'h09); cw(0, 8'h3F);
        chk("R5 code 00 no pulse", p_rst, 2'b00);
        chk("R5 reg9 keeps default", wreg(0, 9), 8'hC0);
        cr(0); chk("R3 pointer home after reg9", last_rd, 8'h44);
    endtask

    task automatic t_swap;
        layout_swap = 1'b1;
        cw(1, 8'h0C); cw(1, 8'h9A);
        chk("R1 swapped ctrl write ch1", wreg(1, 12), 8'h9A);
        chk("R1 swapped ch0 untouched", wreg(0, 12), 8'h00);
        cw(1, 8'h0C); cr(1); chk("R1 swapped ctrl read", last_rd, 8'h9A);
        access(1'b1, 1'b1, 1'b1, 32'h1);
        chk("R1 swapped data strobe ch1", last_dws, 2'b10);
        access(1'b0, 1'b1, 1'b0, 32'h0);
        chk("R1 swapped data read ch0", last_drs, 2'b01);
        layout_swap = 1'b0;
    endtask

    task automatic t_wide;
        cw(0, 32'hABCD_EF0B); cw(0, 32'hFFFF_FF21);
        chk("R10 low byte only", wreg(0, 11), 8'h21);
        cw(0, 32'hFFFF_0000); cr(0);
        chk("R10 upper bits do not move pointer", last_rd, 8'h44);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pointer();
        t_point_high();
        t_commands();
        t_data();
        t_resets();
        t_swap();
        t_wide();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule